// File: doc/BRIEF.md
# Multi-mode 12-bit timer/counter

This block is a 12-bit up-counter. Software loads a start value into it, and when the count wraps it raises a one-cycle interrupt request. A 4-bit command word selects one of three ways of counting. In event mode the counter steps once for each rising edge of an external trigger pin. In timer mode it steps on ticks taken from a free-running prescaler. In pulse-width mode it steps on prescaler ticks only while the external pin is high. The external pin is asynchronous, so it first passes through a two-flop synchronizer and then an edge detector. One physical edge therefore gives exactly one step.

Software reaches the counter through three 4-bit nibble slots: low, middle and high. It has a write port and a separate read port, each with its own slot select. To get N steps before the interrupt, load 1000h minus N. For example, a preset of F0Ah gives 0F6h steps. Interrupt arbitration is not part of this block; the overflow pulse is its only output to the rest of the system.

The block has no streaming data path, so every pin is a plain control or status signal.

Top module: `tmr12_timer`

## Requirements
- R1: After reset the count reads 000h, `ovf_irq` is low and the command word is 0000b, which means counting is disabled.
- R2: When `nib_we` is high, the nibble selected by `nib_wsel` is replaced at the next clock edge and the other two nibbles keep their values. Select 0 is bits 3:0, select 1 is bits 7:4 and select 2 is bits 11:8. `nib_rdata` shows the nibble selected by `nib_rsel` with the same mapping. Select 3 writes nothing and reads 0.
- R3: While command bit 2 (enable) is 0, the count does not change, whatever `trig_in`, `src_internal` or the prescaler are doing.
- R4: Event mode is command bit 3 = 0 with `src_internal` = 0. In this mode each low-to-high change of `trig_in` adds exactly one. The new value shows after the third rising clock edge following the pin change, and not after the second. Falling edges and a steady level add nothing.
- R5: Timer mode is command bit 3 = 0 with `src_internal` = 1. In this mode the count steps once every 2^(3+2*T) clock cycles, where T is command bits 1:0 (T=0 gives 8 cycles, T=1 gives 32, T=3 gives 512).
- R6: Pulse-width mode is command bit 3 = 1, and `src_internal` is ignored. In this mode the count steps at the command bits 1:0 prescaler rate while the synchronized `trig_in` is high, and holds while it is low.
- R7: A step from FFFh gives 000h, and counting then goes on from 000h. `ovf_irq` is high for exactly one cycle, in the cycle that follows the wrapping edge. It is never high at any other time.
- R8: With a preset of 1000h-N, the overflow request comes after exactly N steps. A preset of F0Ah in timer mode with T=0 overflows after 0F6h steps, which is 1968 cycles, give or take one prescaler period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trig_in | input | 1 | Asynchronous external trigger / gate pin |
| src_internal | input | 1 | When command bit 3 is 0, picks timer mode (1) or event mode (0) |
| cmd_we | input | 1 | Loads `cmd_data` into the command register |
| cmd_data | input | 4 | Command: bit 3 gate mode, bit 2 enable, bits 1:0 prescaler tap |
| nib_we | input | 1 | Nibble write strobe |
| nib_wsel | input | 2 | Nibble slot to write |
| nib_wdata | input | 4 | Nibble write value |
| nib_rsel | input | 2 | Nibble slot to read |
| nib_rdata | output | 4 | Selected nibble of the current count |
| ovf_irq | output | 1 | One-cycle overflow request |

## Verification
Wrong internal state shows up at the nibble read port and on `ovf_irq`. A mistake in synchronizer depth moves the first visible step of an event off the third clock edge. A prescaler tap error changes the spacing between successive steps in timer mode, and that shows within one tap period. A bad wrap or a stretched pulse appears at the one edge where FFFh rolls over, and a gate leak shows as the count drifting during a low-pin window. The directed scenarios read the counter back after each stimulus, so each of these faults is seen within a few cycles, or within one prescaler period.

// File: rtl/tmr12_pkg.sv
`timescale 1ns/1ps
package tmr12_pkg;

  typedef enum logic [1:0] {
    MODE_EVENT = 2'd0,
    MODE_TIMER = 2'd1,
    MODE_PULSE = 2'd2
  } tmr_mode_e;

  typedef struct packed {
    logic       gate;
    logic       en;
    logic [1:0] tap;
  } tmr_cmd_t;

  function automatic tmr_mode_e decode_mode(input tmr_cmd_t c, input logic internal);
    if (c.gate)        return MODE_PULSE;
    else if (internal) return MODE_TIMER;
    else               return MODE_EVENT;
  endfunction

endpackage

// File: rtl/tmr12_sync_edge.sv
`timescale 1ns/1ps
module tmr12_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic level,
  output logic rise
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], async_in};
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign level = sync_q[STAGES-1];
  assign rise  = sync_q[STAGES-1] & ~prev_q;

  // R4
  rise_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise);
endmodule

// File: rtl/tmr12_prescale.sv
`timescale 1ns/1ps
module tmr12_prescale #(
  parameter int TAP_BASE = 3,
  parameter int TAP_STEP = 2,
  parameter int NTAP     = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  output logic [NTAP-1:0] tick
);
  localparam int PRE_W = TAP_BASE + TAP_STEP * (NTAP - 1);

  logic [PRE_W-1:0] pre_q;

  always_ff @(posedge clk) begin
    if (!rst_n) pre_q <= '0;
    else        pre_q <= pre_q + 1'b1;
  end

  for (genvar i = 0; i < NTAP; i++) begin : g_tap
    localparam int TW = TAP_BASE + TAP_STEP * i;
    assign tick[i] = &pre_q[TW-1:0];
    if (i > 0) begin : g_nest
      // R5
      tap_nest_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick[i] |-> tick[i-1]);
    end
  end
endmodule

// File: rtl/tmr12_core.sv
`timescale 1ns/1ps
module tmr12_core #(
  parameter int NIB_W   = 4,
  parameter int NUM_NIB = 3,
  parameter int SEL_W   = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       inc,
  input  logic                       wr_en,
  input  logic [SEL_W-1:0]           wr_sel,
  input  logic [NIB_W-1:0]           wr_data,
  input  logic [SEL_W-1:0]           rd_sel,
  output logic [NIB_W-1:0]           rd_data,
  output logic [NIB_W*NUM_NIB-1:0]   count,
  output logic                       wrap_pulse
);
  localparam int CNT_W = NIB_W * NUM_NIB;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] wr_val;
  logic             wr_hit;

  always_comb begin
    wr_val = cnt_q;
    wr_hit = 1'b0;
    for (int i = 0; i < NUM_NIB; i++) begin
      if (wr_en && wr_sel == SEL_W'(i)) begin
        wr_val[i*NIB_W +: NIB_W] = wr_data;
        wr_hit = 1'b1;
      end
    end
  end

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < NUM_NIB; i++) begin
      if (rd_sel == SEL_W'(i)) rd_data = cnt_q[i*NIB_W +: NIB_W];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q      <= '0;
      wrap_pulse <= 1'b0;
    end else begin
      wrap_pulse <= 1'b0;
      if (wr_hit) begin
        cnt_q <= wr_val;
      end else if (inc) begin
        cnt_q      <= cnt_q + 1'b1;
        wrap_pulse <= &cnt_q;
      end
    end
  end

  assign count = cnt_q;

  // R7
  ovf_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_pulse |-> (cnt_q == '0));
  // R7
  ovf_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_pulse |=> !wrap_pulse);
  // R4
  step_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> (cnt_q == $past(cnt_q) || cnt_q == CNT_W'($past(cnt_q) + 1'b1)));
endmodule

// File: rtl/tmr12_timer.sv
`timescale 1ns/1ps
module tmr12_timer #(
  parameter int NIB_W    = 4,
  parameter int NUM_NIB  = 3,
  parameter int TAP_BASE = 3,
  parameter int TAP_STEP = 2,
  parameter int SYNC_N   = 2,
  localparam int SEL_W   = 2,
  localparam int NTAP    = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             trig_in,
  input  logic             src_internal,
  input  logic             cmd_we,
  input  logic [3:0]       cmd_data,
  input  logic             nib_we,
  input  logic [SEL_W-1:0] nib_wsel,
  input  logic [NIB_W-1:0] nib_wdata,
  input  logic [SEL_W-1:0] nib_rsel,
  output logic [NIB_W-1:0] nib_rdata,
  output logic             ovf_irq
);
  import tmr12_pkg::*;

  localparam int CNT_W = NIB_W * NUM_NIB;

  tmr_cmd_t         cmd_q;
  tmr_mode_e        mode;
  logic [NTAP-1:0]  tick;
  logic             tick_sel;
  logic             trig_lvl;
  logic             trig_rise;
  logic             inc;
  logic [CNT_W-1:0] count;

  always_ff @(posedge clk) begin
    if (!rst_n)      cmd_q <= '0;
    else if (cmd_we) cmd_q <= tmr_cmd_t'(cmd_data);
  end

  tmr12_sync_edge #(.STAGES(SYNC_N)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (trig_in),
    .level    (trig_lvl),
    .rise     (trig_rise)
  );

  tmr12_prescale #(.TAP_BASE(TAP_BASE), .TAP_STEP(TAP_STEP), .NTAP(NTAP)) u_pre (
    .clk   (clk),
    .rst_n (rst_n),
    .tick  (tick)
  );

  assign mode     = decode_mode(cmd_q, src_internal);
  assign tick_sel = tick[cmd_q.tap];

  always_comb begin
    unique case (mode)
      MODE_EVENT: inc = cmd_q.en & trig_rise;
      MODE_TIMER: inc = cmd_q.en & tick_sel;
      MODE_PULSE: inc = cmd_q.en & tick_sel & trig_lvl;
      default:    inc = 1'b0;
    endcase
  end

  tmr12_core #(.NIB_W(NIB_W), .NUM_NIB(NUM_NIB), .SEL_W(SEL_W)) u_core (
    .clk        (clk),
    .rst_n      (rst_n),
    .inc        (inc),
    .wr_en      (nib_we),
    .wr_sel     (nib_wsel),
    .wr_data    (nib_wdata),
    .rd_sel     (nib_rsel),
    .rd_data    (nib_rdata),
    .count      (count),
    .wrap_pulse (ovf_irq)
  );

  // R3
  hold_disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmd_q.en && !nib_we) |=> $stable(count));
  // R6
  gate_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_PULSE && !trig_lvl && !nib_we) |=> $stable(count));
  // R4
  event_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_EVENT && !trig_rise && !nib_we) |=> $stable(count));
endmodule

// File: tb/tmr12_timer_bench.sv
`timescale 1ns/1ps
module tmr12_timer_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       trig_in = 1'b0;
  logic       src_internal = 1'b0;
  logic       cmd_we = 1'b0;
  logic [3:0] cmd_data = '0;
  logic       nib_we = 1'b0;
  logic [1:0] nib_wsel = '0;
  logic [3:0] nib_wdata = '0;
  logic [1:0] nib_rsel = '0;
  logic [3:0] nib_rdata;
  logic       ovf_irq;

  int vectors = 0;
  int fails   = 0;
  int irq_cnt = 0;
  int irq_run = 0;
  int irq_max = 0;
  bit done    = 1'b0;

  always #10 clk = ~clk;

  tmr12_timer u_tmr12_timer (
    .clk(clk), .rst_n(rst_n), .trig_in(trig_in), .src_internal(src_internal),
    .cmd_we(cmd_we), .cmd_data(cmd_data), .nib_we(nib_we), .nib_wsel(nib_wsel),
    .nib_wdata(nib_wdata), .nib_rsel(nib_rsel), .nib_rdata(nib_rdata), .ovf_irq(ovf_irq)
  );

  always @(negedge clk) begin
    if (rst_n && ovf_irq) begin
      irq_cnt++;
      irq_run++;
      if (irq_run > irq_max) irq_max = irq_run;
    end else begin
      irq_run = 0;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic chk_rng(input string req, input int act, input int lo, input int hi);
    vectors++;
    if (act < lo || act > hi) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d..%0d", req, act, lo, hi);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic read12(output int v);
    nib_rsel = 2'd0; #1 v = int'(nib_rdata);
    nib_rsel = 2'd1; #1 v = v | (int'(nib_rdata) << 4);
    nib_rsel = 2'd2; #1 v = v | (int'(nib_rdata) << 8);
  endtask

  task automatic set_cmd(input logic [3:0] c);
    @(negedge clk); cmd_we = 1'b1; cmd_data = c;
    @(negedge clk); cmd_we = 1'b0;
  endtask

  task automatic wr_nib(input logic [1:0] s, input logic [3:0] d);
    @(negedge clk); nib_we = 1'b1; nib_wsel = s; nib_wdata = d;
    @(negedge clk); nib_we = 1'b0;
  endtask

  task automatic preset(input int v);
    wr_nib(2'd0, v[3:0]); wr_nib(2'd1, v[7:4]); wr_nib(2'd2, v[11:8]);
  endtask

  task automatic pulse_trig();
    @(negedge clk); trig_in = 1'b1;
    cyc(4); trig_in = 1'b0;
    cyc(4);
  endtask

  task automatic t_reset();
    int v;
    @(negedge clk); read12(v);
    chk("R1 count after reset", v, 0);
    chk("R1 irq after reset", int'(ovf_irq), 0);
    pulse_trig(); pulse_trig();
    read12(v);
    chk("R1 command disabled at reset", v, 0);
  endtask

  task automatic t_nibble();
    int v;
    preset(12'h35A);
    read12(v);
    chk("R2 three nibble write", v, 12'h35A);
    wr_nib(2'd1, 4'hC);
    read12(v);
    chk("R2 middle only", v, 12'h3CA);
    wr_nib(2'd3, 4'hF);
    read12(v);
    chk("R2 select 3 writes nothing", v, 12'h3CA);
    nib_rsel = 2'd3; #1;
    chk("R2 select 3 reads zero", int'(nib_rdata), 0);
  endtask

  task automatic t_disabled();
    int v;
    preset(12'h100);
    src_internal = 1'b1;
    set_cmd(4'b0000);
    cyc(600);
    src_internal = 1'b0;
    pulse_trig(); pulse_trig();
    set_cmd(4'b1011);
    trig_in = 1'b1; cyc(600); trig_in = 1'b0; cyc(4);
    read12(v);
    chk("R3 disabled holds", v, 12'h100);
  endtask

  task automatic t_event();
    int v;
    int base;
    src_internal = 1'b0;
    preset(12'h020);
    set_cmd(4'b0100);
    read12(base);
    @(negedge clk); trig_in = 1'b1;
    @(posedge clk); @(posedge clk);
    @(negedge clk); read12(v);
    chk("R4 no step after second edge", v, base);
    @(negedge clk); read12(v);
    chk("R4 step after third edge", v, base + 1);
    cyc(20);
    read12(v);
    chk("R4 steady high adds nothing", v, base + 1);
    trig_in = 1'b0; cyc(20);
    read12(v);
    chk("R4 falling edge adds nothing", v, base + 1);
    for (int k = 0; k < 5; k++) pulse_trig();
    read12(v);
    chk("R4 five edges", v, base + 6);
    set_cmd(4'b0000);
  endtask

  task automatic measure(input logic [1:0] tap, input int period);
    int v;
    int prev;
    int c1 = -1;
    int c2 = -1;
    int c3 = -1;
    src_internal = 1'b1;
    preset(12'h000);
    set_cmd({2'b01, tap});
    nib_rsel = 2'd0; #1 prev = int'(nib_rdata);
    for (int t = 0; t < period * 4 && c3 < 0; t++) begin
      @(negedge clk); #1 v = int'(nib_rdata);
      if (v != prev) begin
        if (c1 < 0) c1 = t; else if (c2 < 0) c2 = t; else c3 = t;
        prev = v;
      end
    end
    chk("R5 step spacing first", c2 - c1, period);
    chk("R5 step spacing second", c3 - c2, period);
    set_cmd(4'b0000);
    src_internal = 1'b0;
  endtask

  task automatic t_timer();
    measure(2'd0, 8);
    measure(2'd1, 32);
    measure(2'd3, 512);
  endtask

  task automatic t_pulse();
    int v1;
    int v2;
    src_internal = 1'b1;
    preset(12'h000);
    set_cmd(4'b1100);
    cyc(40);
    read12(v1);
    chk("R6 low level holds", v1, 0);
    trig_in = 1'b1; cyc(80);
    trig_in = 1'b0; cyc(8);
    read12(v1);
    chk_rng("R6 high window count", v1, 9, 11);
    cyc(64);
    read12(v2);
    chk("R6 holds after low", v2, v1);
    set_cmd(4'b0000);
    src_internal = 1'b0;
  endtask

  task automatic t_overflow();
    int v;
    int i0;
    src_internal = 1'b0;
    preset(12'hFFC);
    set_cmd(4'b0100);
    i0 = irq_cnt;
    for (int k = 0; k < 3; k++) pulse_trig();
    read12(v);
    chk("R7 at FFF", v, 12'hFFF);
    chk("R7 no early irq", irq_cnt - i0, 0);
    pulse_trig();
    read12(v);
    chk("R7 wraps to zero", v, 0);
    chk("R7 one request", irq_cnt - i0, 1);
    chk("R7 request one cycle wide", irq_max, 1);
    pulse_trig();
    read12(v);
    chk("R7 continues from zero", v, 1);
    chk("R7 no extra request", irq_cnt - i0, 1);
    set_cmd(4'b0000);
  endtask

  task automatic t_preset();
    int i0;
    int t;
    preset(12'hF0A);
    src_internal = 1'b1;
    i0 = irq_cnt;
    set_cmd(4'b0100);
    t = 0;
    while (irq_cnt == i0 && t < 4000) begin
      @(negedge clk); t++;
    end
    chk_rng("R8 F0A overflow time", t, 246 * 8 - 8, 246 * 8 + 8);
    set_cmd(4'b0000);
    src_internal = 1'b0;
  endtask

  initial begin
    cyc(3);
    rst_n = 1'b1;
    t_reset();
    t_nibble();
    t_disabled();
    t_event();
    t_timer();
    t_pulse();
    t_overflow();
    t_preset();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      done = 1'b1;
      vectors++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule